// File: doc/BRIEF.md
# Channel Frequency Sweep and Modulation Unit

This unit owns the 11-bit pitch register of a single sound channel and rewrites it on a programmable schedule. It has two functions. In sweep mode each step takes the current pitch, shifts it right by a programmed amount, and adds the result to the pitch or subtracts it. In modulation mode each step adds a signed 8-bit entry from a 32-entry table to the pitch that software last wrote. Each candidate pitch is computed ahead of time and held. It is committed only when the step timer runs out, and only while modulation is active.

A three-state end-of-table mask decides whether the unit keeps running after the table has been walked once. The states are running (0), reached the end (1) and finished (2). The step timer counts base-clock ticks. Its reload is the programmed interval times one of two base periods. Software reaches the unit through four write strobes: the pitch, the sweep/modulation settings, the envelope register and the table. Two channel pulses start and stop the channel.

Top module: `fmod_sweep_unit`

## Requirements
- R1: After reset the pitch is 0, the active flag is 0, the channel is off, the table holds zeros, the index and mask are 0 and the timer is 0.
- R2: The active flag is 1 only if the enable bit is set, the interval is nonzero, and either the mask is not 2 or the function is modulation (func=1) with repeat set.
- R3: In modulation mode the candidate is the written pitch plus the table entry at the current index, read as 8-bit two's complement. The sum is clamped to 0..2047. Table entry k is written at address k.
- R4: In sweep mode (func=0) the delta is the current pitch shifted right by the shift field. Direction 0 adds the delta and direction 1 subtracts it, with the result clamped at 0. An add result above 2047 turns the channel off at commit and leaves the pitch unchanged.
- R5: The pitch changes only on a pitch write or at a timer expiry while the flag is active. At an expiry the held candidate becomes the pitch.
- R6: At each active expiry of a running channel the index increments. From index 31 the index instead sets the mask to 1. The index then wraps to 0 only if repeat is set and otherwise stays at 31.
- R7: Whenever a fresh candidate is prepared while the mask is 1 and the function is modulation, the mask moves to 2 and the flag is re-evaluated first. Without repeat, modulation therefore stops after all 32 entries have been applied.
- R8: A tick while the timer is above 1 decrements it. Any other tick is an expiry. The reload equals interval×BASE_A ticks with clock select 0, or interval×BASE_B ticks with clock select 1.
- R9: A start pulse turns the channel on, reloads the timer, clears the index and mask, re-evaluates the flag and prepares a fresh candidate. No expiry is taken in that cycle.
- R10: A settings write and an envelope write each re-evaluate the flag and prepare a fresh candidate.
- R11: A stop pulse turns the channel off. At an expiry while the channel is off, the held candidate is still applied if the flag is active, but the index does not move and the timer is not reloaded.
- R12: A settings write loads the timer with its new period only if that period is shorter than the ticks remaining. The timer never exceeds the period of the current settings.
- R13: Events in one cycle apply in a fixed order: pitch write, stop, tick/expiry, settings write, envelope write, start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_we | input | 1 | Pitch write strobe |
| freq_wdata | input | 11 | Pitch written by software |
| chan_start | input | 1 | Channel start pulse |
| chan_stop | input | 1 | Channel stop pulse |
| sweep_we | input | 1 | Settings write strobe |
| sweep_enable | input | 1 | Enable bit |
| sweep_func | input | 1 | 0 sweep, 1 modulation |
| sweep_rep | input | 1 | Repeat the table |
| sweep_clk_sel | input | 1 | 0 selects BASE_A, 1 selects BASE_B |
| sweep_interval | input | 3 | Step interval multiplier |
| sweep_shift | input | 3 | Sweep shift amount |
| sweep_dir | input | 1 | 0 add, 1 subtract |
| env_we | input | 1 | Envelope register write strobe |
| tick | input | 1 | Base clock tick |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table write address |
| tbl_wdata | input | 8 | Table entry, two's complement |
| freq_cur | output | 11 | Current pitch |
| mod_active | output | 1 | Active flag |
| chan_on | output | 1 | Channel running |

## Verification
The two functions that can meet in one cycle are a timer-expiry commit and a settings write (R13). The write re-evaluates the flag, may shorten the timer and replaces the held candidate, while the expiry commits the old candidate and advances the index. The bench forces the collision by issuing settings writes on several consecutive cycles across an expiry while alternating function and direction. Its per-cycle reference model applies the commit first and the write second, and every output is compared on every clock, so any reordering shows up as a pitch or flag mismatch a few cycles later.

// File: rtl/fmod_pkg.sv
// Shared constants and types of the sweep/modulation unit.
// Assumes a fixed register layout: 11-bit pitch, 32-entry table of 8-bit samples.
package fmod_pkg;
    parameter int FM_FREQ_W = 11;
    parameter int FM_IDX_W  = 5;
    parameter int FM_DEPTH  = 1 << FM_IDX_W;
    parameter int FM_SAMP_W = 8;
    parameter int FM_INTV_W = 3;
    parameter int FM_SHF_W  = 3;

    typedef enum logic [1:0] {
        MASK_RUN  = 2'd0,
        MASK_END  = 2'd1,
        MASK_DONE = 2'd2
    } mask_e;

    typedef struct packed {
        logic                 enable;
        logic                 func;
        logic                 rep;
        logic                 clk_sel;
        logic [FM_INTV_W-1:0] interval;
        logic [FM_SHF_W-1:0]  shift;
        logic                 dir;
    } cfg_t;
endpackage

// File: rtl/fmod_table.sv
// Sample table: one synchronous write port and one combinational read port.
// Assumes a read in the same cycle as a write to that entry returns the old value.
module fmod_table #(
    parameter int DEPTH  = 32,
    parameter int IDX_W  = 5,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [SAMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [SAMP_W-1:0] rd_data
);
    logic [SAMP_W-1:0] mem_q [DEPTH];

    // Store one entry per write strobe; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the entry at the requested index.
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/fmod_calc.sv
// Candidate pitch datapath for both functions.
// Assumes func=0 selects sweep, func=1 selects table modulation.
module fmod_calc import fmod_pkg::*; (
    input  logic                 func,
    input  logic                 dir,
    input  logic [FM_SHF_W-1:0]  shift,
    input  logic [FM_FREQ_W-1:0] cur,
    input  logic [FM_FREQ_W-1:0] wr,
    input  logic [FM_SAMP_W-1:0] sample,
    output logic [FM_FREQ_W-1:0] cand,
    output logic                 ovf
);
    localparam int SUM_W = FM_FREQ_W + 2;
    localparam logic [FM_FREQ_W-1:0] FREQ_MAX = '1;

    logic [FM_FREQ_W-1:0]    delta;
    logic [FM_FREQ_W:0]      up_sum;
    logic signed [SUM_W-1:0] mod_sum;

    // Form the sweep sum and the modulated sum, then pick and clamp one.
    always_comb begin
        delta   = cur >> shift;
        up_sum  = {1'b0, cur} + {1'b0, delta};
        mod_sum = $signed({2'b00, wr}) +
                  $signed({{(SUM_W-FM_SAMP_W){sample[FM_SAMP_W-1]}}, sample});
        ovf     = 1'b0;
        if (func) begin
            if (mod_sum < 0)
                cand = '0;
            else if (mod_sum > $signed({2'b00, FREQ_MAX}))
                cand = FREQ_MAX;
            else
                cand = mod_sum[FM_FREQ_W-1:0];
        end else if (!dir) begin
            cand = up_sum[FM_FREQ_W-1:0];
            ovf  = up_sum[FM_FREQ_W];
        end else begin
            cand = (cur >= delta) ? cur - delta : '0;
        end
    end
endmodule

// File: rtl/fmod_sweep_unit.sv
// Sweep / modulation controller for one channel pitch.
// Candidate is prepared ahead and committed at timer expiry while active.
// Same-cycle order: pitch write, stop, tick, settings write, envelope write, start.
module fmod_sweep_unit import fmod_pkg::*; #(
    parameter int BASE_A = 19200,
    parameter int BASE_B = 153600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 freq_we,
    input  logic [FM_FREQ_W-1:0] freq_wdata,
    input  logic                 chan_start,
    input  logic                 chan_stop,
    input  logic                 sweep_we,
    input  logic                 sweep_enable,
    input  logic                 sweep_func,
    input  logic                 sweep_rep,
    input  logic                 sweep_clk_sel,
    input  logic [FM_INTV_W-1:0] sweep_interval,
    input  logic [FM_SHF_W-1:0]  sweep_shift,
    input  logic                 sweep_dir,
    input  logic                 env_we,
    input  logic                 tick,
    input  logic                 tbl_we,
    input  logic [FM_IDX_W-1:0]  tbl_addr,
    input  logic [FM_SAMP_W-1:0] tbl_wdata,
    output logic [FM_FREQ_W-1:0] freq_cur,
    output logic                 mod_active,
    output logic                 chan_on
);
    localparam int TMR_W = $clog2(((1 << FM_INTV_W) - 1) * BASE_B + 1);
    localparam logic [FM_IDX_W-1:0] IDX_LAST = FM_IDX_W'(FM_DEPTH - 1);

    function automatic logic [TMR_W-1:0] period_of(cfg_t c);
        return TMR_W'(c.interval) * (c.clk_sel ? TMR_W'(BASE_B) : TMR_W'(BASE_A));
    endfunction

    function automatic logic active_rule(cfg_t c, mask_e m);
        return c.enable && (c.interval != '0) &&
               ((m != MASK_DONE) || (c.func && c.rep));
    endfunction

    logic [FM_FREQ_W-1:0] cur_q, wr_q, nxt_q;
    logic                 nxt_ovf_q, act_q, on_q;
    logic [FM_IDX_W-1:0]  idx_q;
    mask_e                mask_q;
    logic [TMR_W-1:0]     tmr_q;
    cfg_t                 cfg_q;

    cfg_t                 in_cfg;
    logic [TMR_W-1:0]     p_new;
    logic [FM_FREQ_W-1:0] a_cur, a_wr;
    logic                 a_on, a_act, recheck, recompute;
    logic [FM_IDX_W-1:0]  a_idx;
    mask_e                a_mask;
    logic [TMR_W-1:0]     a_tmr;
    cfg_t                 a_cfg;

    logic [FM_SAMP_W-1:0] sample;
    logic [FM_FREQ_W-1:0] cand;
    logic                 cand_ovf;

    mask_e                b_mask;
    logic                 b_act, b_ovf;
    logic [FM_FREQ_W-1:0] b_nxt;

    // Gather the settings presented with a settings write.
    always_comb begin
        in_cfg.enable   = sweep_enable;
        in_cfg.func     = sweep_func;
        in_cfg.rep      = sweep_rep;
        in_cfg.clk_sel  = sweep_clk_sel;
        in_cfg.interval = sweep_interval;
        in_cfg.shift    = sweep_shift;
        in_cfg.dir      = sweep_dir;
        p_new           = period_of(in_cfg);
    end

    // Stage A: apply this cycle's events in their fixed order.
    always_comb begin
        a_cur = cur_q;  a_wr = wr_q;   a_on = on_q;   a_idx = idx_q;
        a_mask = mask_q; a_act = act_q; a_tmr = tmr_q; a_cfg = cfg_q;
        recheck = 1'b0; recompute = 1'b0;
        if (freq_we) begin
            a_cur = freq_wdata;
            a_wr  = freq_wdata;
        end
        if (chan_stop) a_on = 1'b0;
        if (tick && !chan_start) begin
            if (a_tmr > TMR_W'(1)) begin
                a_tmr = a_tmr - TMR_W'(1);
            end else begin
                if (a_act) begin
                    if (nxt_ovf_q) a_on = 1'b0;
                    else           a_cur = nxt_q;
                end
                if (a_on) begin
                    if (a_act) begin
                        if (a_idx != IDX_LAST) begin
                            a_idx = a_idx + 1'b1;
                        end else begin
                            a_mask = MASK_END;
                            if (a_cfg.rep) a_idx = '0;
                        end
                        a_tmr = period_of(a_cfg);
                    end
                    recompute = 1'b1;
                end
            end
        end
        if (sweep_we) begin
            a_cfg = in_cfg;
            if (p_new < a_tmr) a_tmr = p_new;
            recheck = 1'b1; recompute = 1'b1;
        end
        if (env_we) begin
            recheck = 1'b1; recompute = 1'b1;
        end
        if (chan_start) begin
            a_on   = 1'b1;
            a_tmr  = period_of(a_cfg);
            a_idx  = '0;
            a_mask = MASK_RUN;
            recheck = 1'b1; recompute = 1'b1;
        end
        if (recheck) a_act = active_rule(a_cfg, a_mask);
    end

    fmod_table #(
        .DEPTH (FM_DEPTH),
        .IDX_W (FM_IDX_W),
        .SAMP_W(FM_SAMP_W)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_addr(tbl_addr),
        .wr_data(tbl_wdata),
        .rd_addr(a_idx),
        .rd_data(sample)
    );

    fmod_calc calc_i (
        .func  (a_cfg.func),
        .dir   (a_cfg.dir),
        .shift (a_cfg.shift),
        .cur   (a_cur),
        .wr    (a_wr),
        .sample(sample),
        .cand  (cand),
        .ovf   (cand_ovf)
    );

    // Stage B: end-of-table mask step, then hold the fresh candidate.
    always_comb begin
        b_mask = a_mask; b_act = a_act; b_nxt = nxt_q; b_ovf = nxt_ovf_q;
        if (recompute) begin
            if (a_mask == MASK_END && a_cfg.func) begin
                b_mask = MASK_DONE;
                b_act  = active_rule(a_cfg, MASK_DONE);
            end
            if (b_act) begin
                b_nxt = cand;
                b_ovf = cand_ovf;
            end
        end
    end

    // Register the resolved state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0; wr_q <= '0; nxt_q <= '0; nxt_ovf_q <= 1'b0;
            act_q <= 1'b0; on_q <= 1'b0; idx_q <= '0; mask_q <= MASK_RUN;
            tmr_q <= '0; cfg_q <= '0;
        end else begin
            cur_q <= a_cur; wr_q <= a_wr; nxt_q <= b_nxt; nxt_ovf_q <= b_ovf;
            act_q <= b_act; on_q <= a_on; idx_q <= a_idx; mask_q <= b_mask;
            tmr_q <= a_tmr; cfg_q <= a_cfg;
        end
    end

    assign freq_cur   = cur_q;
    assign mod_active = act_q;
    assign chan_on    = on_q;

    // R5: without a pitch write or an active flag the pitch holds.
    a_r5_pitch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!freq_we && !mod_active) |=> $stable(freq_cur));

    // R2: the flag implies enable and a nonzero interval.
    a_r2_flag_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mod_active |-> (cfg_q.enable && cfg_q.interval != '0));

    // R6: the index only steps by one or returns to zero.
    a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + 1'b1 || idx_q == '0));

    // R7: the mask never leaves its three states.
    a_r7_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q != mask_e'(2'd3));

    // R11: a stopped channel keeps its index until restarted.
    a_r11_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !chan_start) |=> $stable(idx_q));

    // R12: the timer never exceeds the current period.
    a_r12_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= period_of(cfg_q));
endmodule

// File: tb/fmod_sweep_unit_tb_top.sv
module fmod_sweep_unit_tb_top;
    localparam int BA = 3;
    localparam int BB = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freq_we = 0, chan_start = 0, chan_stop = 0, sweep_we = 0;
    logic [10:0] freq_wdata = '0;
    logic        sweep_enable = 0, sweep_func = 0, sweep_rep = 0, sweep_clk_sel = 0;
    logic [2:0]  sweep_interval = '0, sweep_shift = '0;
    logic        sweep_dir = 0, env_we = 0, tick = 0, tbl_we = 0;
    logic [4:0]  tbl_addr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic [10:0] freq_cur;
    logic        mod_active, chan_on;

    int checks = 0, fails = 0, tick_div = 1, tcnt = 0;
    bit cmp_en = 0, done = 0;
    string tag = "R1";

    // reference model state
    int m_cur, m_wr, m_nxt, m_idx, m_mask, m_tmr;
    bit m_ovf, m_act, m_on;
    int c_en, c_func, c_rep, c_sel, c_iv, c_sh, c_dir;
    int tbl [32];

    always #4 clk = ~clk;

    fmod_sweep_unit #(.BASE_A(BA), .BASE_B(BB)) dut_i (
        .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_wdata(freq_wdata),
        .chan_start(chan_start), .chan_stop(chan_stop), .sweep_we(sweep_we),
        .sweep_enable(sweep_enable), .sweep_func(sweep_func), .sweep_rep(sweep_rep),
        .sweep_clk_sel(sweep_clk_sel), .sweep_interval(sweep_interval),
        .sweep_shift(sweep_shift), .sweep_dir(sweep_dir), .env_we(env_we),
        .tick(tick), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .freq_cur(freq_cur), .mod_active(mod_active), .chan_on(chan_on));

    function automatic bit rule(int mask);
        return c_en != 0 && c_iv != 0 && (mask != 2 || (c_func != 0 && c_rep != 0));
    endfunction

    function automatic int period();
        return c_iv * (c_sel != 0 ? BB : BA);
    endfunction

    // Behavioural model of the requirements, advanced on every clock.
    always @(posedge clk) begin
        bit rc, rk;
        int v, d, p;
        if (!rst_n) begin
            m_cur = 0; m_wr = 0; m_nxt = 0; m_idx = 0; m_mask = 0; m_tmr = 0;
            m_ovf = 0; m_act = 0; m_on = 0;
            c_en = 0; c_func = 0; c_rep = 0; c_sel = 0; c_iv = 0; c_sh = 0; c_dir = 0;
            foreach (tbl[k]) tbl[k] = 0;
        end else begin
            rc = 0; rk = 0;
            if (freq_we) begin m_cur = freq_wdata; m_wr = freq_wdata; end
            if (chan_stop) m_on = 0;
            if (tick && !chan_start) begin
                if (m_tmr > 1) m_tmr--;
                else begin
                    if (m_act) begin
                        if (m_ovf) m_on = 0; else m_cur = m_nxt;
                    end
                    if (m_on) begin
                        if (m_act) begin
                            if (m_idx < 31) m_idx++;
                            else begin m_mask = 1; if (c_rep != 0) m_idx = 0; end
                            m_tmr = period();
                        end
                        rk = 1;
                    end
                end
            end
            if (sweep_we) begin
                c_en = sweep_enable; c_func = sweep_func; c_rep = sweep_rep;
                c_sel = sweep_clk_sel; c_iv = sweep_interval; c_sh = sweep_shift;
                c_dir = sweep_dir;
                p = period();
                if (p < m_tmr) m_tmr = p;
                rc = 1; rk = 1;
            end
            if (env_we) begin rc = 1; rk = 1; end
            if (chan_start) begin
                m_on = 1; m_tmr = period(); m_idx = 0; m_mask = 0; rc = 1; rk = 1;
            end
            if (rc) m_act = rule(m_mask);
            if (rk) begin
                if (m_mask == 1 && c_func != 0) begin m_mask = 2; m_act = rule(2); end
                if (m_act) begin
                    if (c_func != 0) begin
                        v = m_wr + tbl[m_idx];
                        if (v < 0) v = 0;
                        if (v > 2047) v = 2047;
                        m_nxt = v; m_ovf = 0;
                    end else begin
                        d = m_cur >> c_sh;
                        if (c_dir == 0) begin
                            v = m_cur + d;
                            m_ovf = (v > 2047);
                            m_nxt = v % 2048;
                        end else begin
                            v = m_cur - d;
                            if (v < 0) v = 0;
                            m_nxt = v; m_ovf = 0;
                        end
                    end
                end
            end
            if (tbl_we) tbl[tbl_addr] = int'($signed(tbl_wdata));
            cmp_en = 1;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (freq_cur !== 11'(m_cur) || chan_on !== m_on || mod_active !== m_act) begin
                fails++;
                $display("FAIL %s: freq=%0d on=%0b act=%0b expected freq=%0d on=%0b act=%0b",
                         tag, freq_cur, chan_on, mod_active, m_cur, m_on, m_act);
            end
        end
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: leave the negedge, clear pulses, set the next tick.
    task automatic clk1();
        @(posedge clk);
        @(negedge clk);
        freq_we = 0; chan_start = 0; chan_stop = 0; sweep_we = 0; env_we = 0; tbl_we = 0;
        tick = (tcnt % tick_div == 0);
        tcnt++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) clk1();
    endtask

    task automatic wfreq(int f);
        freq_wdata = 11'(f); freq_we = 1; clk1();
    endtask

    task automatic wcfg(bit en, bit fn, bit rp, bit sel, int iv, int sh, bit dr);
        sweep_enable = en; sweep_func = fn; sweep_rep = rp; sweep_clk_sel = sel;
        sweep_interval = 3'(iv); sweep_shift = 3'(sh); sweep_dir = dr;
        sweep_we = 1; clk1();
    endtask

    task automatic start();
        chan_start = 1; clk1();
    endtask

    task automatic wtbl(int a, int d);
        tbl_addr = 5'(a); tbl_wdata = 8'(d); tbl_we = 1; clk1();
    endtask

    initial begin
        run(5);
        tag = "R1";
        check_eq("R1 freq", int'(freq_cur), 0);
        check_eq("R1 active", int'(mod_active), 0);
        check_eq("R1 chan_on", int'(chan_on), 0);
        rst_n = 1; tick = 1;
        run(3);

        // R3/R6: modulation through a varied table with repeat
        tag = "R3";
        for (int i = 0; i < 32; i++) wtbl(i, (i * 29 + 3) & 255);
        wfreq(1000);
        wcfg(1, 1, 1, 0, 1, 0, 0);
        start();
        tag = "R6";
        run(130);
        check_eq("R6 repeat keeps active", int'(mod_active), 1);

        // R7: without repeat modulation ends after entry 31 (-122)
        tag = "R7";
        wcfg(1, 1, 0, 0, 1, 0, 0);
        start();
        run(130);
        check_eq("R7 active after table end", int'(mod_active), 0);
        check_eq("R7 last entry applied", int'(freq_cur), 1000 - 122);

        // R3: clamp high and low
        tag = "R3";
        for (int i = 0; i < 32; i++) wtbl(i, 100);
        wfreq(2040);
        wcfg(1, 1, 1, 0, 1, 0, 0);
        start();
        run(20);
        check_eq("R3 clamp high", int'(freq_cur), 2047);
        for (int i = 0; i < 32; i++) wtbl(i, 8'h80);
        wfreq(5);
        start();
        run(20);
        check_eq("R3 clamp low", int'(freq_cur), 0);

        // R8: slower base with sparse ticks
        tag = "R8";
        for (int i = 0; i < 32; i++) wtbl(i, i - 16);
        wfreq(700);
        tick_div = 2;
        wcfg(1, 1, 1, 1, 2, 0, 0);
        start();
        run(100);
        tick_div = 1;

        // R4: sweep add until overflow turns the channel off
        tag = "R4";
        wfreq(100);
        wcfg(1, 0, 0, 0, 1, 3, 0);
        start();
        run(200);
        check_eq("R4 overflow stops channel", int'(chan_on), 0);
        wfreq(2000);
        wcfg(1, 0, 0, 0, 1, 1, 1);
        start();
        run(80);
        check_eq("R4 subtract settles", int'(freq_cur), 1);

        // R2: enable clear and zero interval drop the flag
        tag = "R2";
        wcfg(0, 1, 1, 0, 1, 0, 0);
        check_eq("R2 enable clear", int'(mod_active), 0);
        wcfg(1, 1, 1, 0, 0, 0, 0);
        check_eq("R2 interval zero", int'(mod_active), 0);

        // R12: shortening write, then a longer one that must not extend
        tag = "R12";
        wfreq(900);
        wcfg(1, 1, 1, 1, 7, 0, 0);
        start();
        run(5);
        wcfg(1, 1, 1, 0, 1, 0, 0);
        run(2);
        wcfg(1, 1, 1, 1, 7, 0, 0);
        run(60);

        // R13/R10: settings writes on consecutive cycles across expiries
        tag = "R13";
        wcfg(1, 1, 1, 0, 1, 0, 0);
        start();
        for (int i = 0; i < 8; i++) wcfg(1, 1'(i % 2), 1, 0, 1, 2, 1'((i / 2) % 2));
        tag = "R10";
        wfreq(1500);
        for (int i = 0; i < 4; i++) begin env_we = 1; clk1(); end
        run(20);

        // R11: stopped channel still applies pending value
        tag = "R11";
        wcfg(1, 1, 1, 0, 1, 0, 0);
        start();
        run(10);
        chan_stop = 1; clk1();
        run(20);
        check_eq("R11 channel off", int'(chan_on), 0);
        tag = "R9";
        start();
        run(20);
        check_eq("R9 restart on", int'(chan_on), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule